// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Timed Masking

This block decides which of up to 32 peripheral interrupt sources and 8 trap sources a CPU should take next. Each peripheral source has a sticky pending flag, an enable bit and a 3-bit priority, all reached through a small register port. Trap sources sit on fixed levels 8 to 15. The best pending request is compared against the current CPU level held inside the block. When the request is higher, the block raises a vector request that carries the source number, whether it is a trap, and its level.

When the CPU accepts a request, the block saves the current level on a 4-entry stack and raises the current level to that of the accepted source. A return restores the saved level. Software can also write the low three bits of the level directly. Writing 7 masks every peripheral source, and writing back the old value unmasks them. A global no-nesting switch keeps peripheral sources from preempting a routine that is running. A down-counter masks peripheral levels 1 to 6 for a programmed number of cycles, while level 7 and all traps stay live.

Top module: `prio_intc`

## Requirements
- R1: After reset every source priority reads 4, all flags, enables and trap flags read 0, the current level is 0, no request is raised, the cycle mask is off and the stack error is low.
- R2: A peripheral source requests only when its flag and enable are both set, its priority is non-zero, and its level {0,priority} is strictly greater than the current level.
- R3: Among eligible peripheral sources the highest priority wins, and the lowest source number wins a tie. `irq_index` gives the source number and `irq_level` gives {0,priority}.
- R4: Trap t (bit t of `trap_event`) has level 8+t and reports `irq_index`=t with `irq_is_trap`=1. A pending trap always beats every peripheral source, and the higher trap number wins among traps. No level write, cycle mask or no-nesting setting holds a trap back while the current level is below 8.
- R5: `ipl_we` loads the current level with {0,`ipl_wdata`} one cycle later, but only while the current level is below 8. A value of 7 masks every peripheral source. Writing a lower value unmasks them again.
- R6: Writing N to the timer register masks peripheral priorities 1 to 6 for exactly N cycles, starting on the cycle after the write. Priority 7 and traps are still raised during that time. Writing again while the counter runs reloads it, and writing 0 cancels the mask.
- R7: While control bit 0 (no-nesting) is set and at least one entry is in service, no peripheral source is raised. Traps still are.
- R8: `irq_ack` with a raised request pushes the current level and loads it with `irq_level`. `irq_ack` without a request has no effect. `irq_ret` (when not acknowledging) pops the saved level if the stack is non-empty. Flags are not cleared by service, so an uncleared source requests again right after the return.
- R9: A peripheral flag is set by a one-cycle `src_event` bit and cleared only by a register write. A set in the same cycle as a clearing write leaves the flag set. Trap flags set from `trap_event` and clear by writing 1 to their bit in the trap register.
- R10: The level stack holds 4 entries. An acknowledge while it is full still raises the current level, stores nothing, and sets `stack_err`, which stays high until reset.
- R11: Register map: `reg_addr[6:5]` selects the register kind and `reg_addr[4:0]` the source. Kind 0 is source config, with bit 0 flag, bit 1 enable and bits 4:2 priority. Kind 1 is control, with bit 0 no-nesting. Kind 2 is the cycle counter, which reads its live value. Kind 3 is the trap flags in bits 7:0. `reg_rdata` shows the addressed register without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register kind and source number |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| src_event | input | 32 | Per-source flag set pulses |
| trap_event | input | 8 | Per-trap flag set pulses |
| ipl_we | input | 1 | Direct current-level write strobe |
| ipl_wdata | input | 3 | Level value for direct write |
| irq_ack | input | 1 | CPU accepts the raised request |
| irq_ret | input | 1 | CPU returns from a service routine |
| irq_valid | output | 1 | A request is raised |
| irq_is_trap | output | 1 | The raised request is a trap |
| irq_index | output | 5 | Source or trap number of the request |
| irq_level | output | 4 | Level of the request |
| cur_level | output | 4 | Current CPU level |
| timed_mask_on | output | 1 | Cycle mask is running |
| stack_err | output | 1 | Sticky stack overflow error |

## Verification
A peripheral event pulse and a software write that clears the same flag can land in the same cycle. The bench drives both on one edge and then reads the flag back, which must read 1, and checks that the source is raised. A second coincidence is a reload of the cycle counter while it is still running. The bench counts cycles from the second write and expects the mask to last its full length from there. Random configurations are checked against a bench model of the arbitration.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int PRIO_W     = 3;
    localparam int LVL_W      = 4;
    localparam int NUM_TRAP   = 8;
    localparam int TRAP_IDX_W = 3;

    localparam logic [PRIO_W-1:0] PRIO_RESET = 3'd4;
    localparam logic [PRIO_W-1:0] PRIO_TOP   = 3'd7;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              en;
        logic              flag;
    } src_cfg_t;

    typedef enum logic [1:0] {
        RK_CFG   = 2'd0,
        RK_CTRL  = 2'd1,
        RK_TIMER = 2'd2,
        RK_TRAP  = 2'd3
    } reg_kind_e;

    function automatic logic user_eligible(src_cfg_t c, logic timed_mask);
        logic live;
        live = c.flag && c.en && (c.prio != '0);
        if (timed_mask && c.prio != PRIO_TOP) live = 1'b0;
        return live;
    endfunction

    function automatic level_t trap_level(logic [TRAP_IDX_W-1:0] t);
        return {1'b1, t};
    endfunction

endpackage

// File: rtl/prio_intc_src_bank.sv
module prio_intc_src_bank
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  src_cfg_t                 wr_cfg,
    input  logic [NUM_SRC-1:0]       pulse,
    output src_cfg_t [NUM_SRC-1:0]   cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_q[i].prio <= PRIO_RESET;
                cfg_q[i].en   <= 1'b0;
                cfg_q[i].flag <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) cfg_q[i] <= wr_cfg;
                // an event wins over a clearing write in the same cycle
                if (pulse[i]) cfg_q[i].flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_intc_user_arb.sv
module prio_intc_user_arb
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    input  logic                   timed_mask,
    input  logic                   hold_user,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx,
    output logic [PRIO_W-1:0]      prio
);

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        prio = '0;
        // scan downwards with >= so the lowest index keeps a tie
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (user_eligible(cfg[i], timed_mask) && cfg[i].prio >= prio) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                prio = cfg[i].prio;
            end
        end
        if (hold_user) hit = 1'b0;
    end

endmodule

// File: rtl/prio_intc_lvl_stack.sv
module prio_intc_lvl_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic                          pop,
    input  logic [W-1:0]                  din,
    output logic [W-1:0]                  dout,
    output logic [$clog2(DEPTH+1)-1:0]    cnt,
    output logic                          ovf
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (push) begin
            if (cnt == CW'(DEPTH)) begin
                ovf <= 1'b1;
            end else begin
                mem[PW'(cnt)] <= din;
                cnt           <= cnt + CW'(1);
            end
        end else if (pop && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign dout = (cnt != '0) ? mem[PW'(cnt - CW'(1))] : '0;

endmodule

// File: rtl/prio_intc_mask_timer.sv
module prio_intc_mask_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             active
);

    always_ff @(posedge clk) begin
        if (rst)                count <= '0;
        else if (load)          count <= load_val;
        else if (count != '0)   count <= count - CNT_W'(1);
    end

    assign active = (count != '0);

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int STACK_DEPTH = 4,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int IDX_W       = ($clog2(NUM_SRC) < TRAP_IDX_W) ? TRAP_IDX_W : $clog2(NUM_SRC),
    parameter int ADDR_W      = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_event,
    input  logic [NUM_TRAP-1:0] trap_event,
    input  logic               ipl_we,
    input  logic [PRIO_W-1:0]  ipl_wdata,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_valid,
    output logic               irq_is_trap,
    output logic [IDX_W-1:0]   irq_index,
    output logic [LVL_W-1:0]   irq_level,
    output logic [LVL_W-1:0]   cur_level,
    output logic               timed_mask_on,
    output logic               stack_err
);

    localparam int SCW = $clog2(STACK_DEPTH + 1);

    reg_kind_e               reg_kind;
    logic [IDX_W-1:0]        reg_idx;
    src_cfg_t [NUM_SRC-1:0]  src_cfg;
    logic [NUM_TRAP-1:0]     trap_q;
    logic [NUM_TRAP-1:0]     trap_clr;
    logic                    trap_any;
    logic [TRAP_IDX_W-1:0]   trap_idx;
    logic                    nonest_q;
    logic                    in_service;
    logic [CNT_W-1:0]        mask_count;
    logic                    user_hit;
    logic [IDX_W-1:0]        user_idx;
    logic [PRIO_W-1:0]       user_prio;
    logic                    win_any;
    level_t                  win_level;
    level_t                  cur_q;
    level_t                  saved_level;
    logic [SCW-1:0]          stk_cnt;
    logic                    take;
    logic                    do_pop;

    assign reg_kind = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
    assign reg_idx  = reg_addr[IDX_W-1:0];

    prio_intc_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_we && reg_kind == RK_CFG),
        .wr_idx (reg_idx),
        .wr_cfg (src_cfg_t'(reg_wdata[4:0])),
        .pulse  (src_event),
        .cfg_q  (src_cfg)
    );

    prio_intc_mask_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (reg_we && reg_kind == RK_TIMER),
        .load_val (reg_wdata[CNT_W-1:0]),
        .count    (mask_count),
        .active   (timed_mask_on)
    );

    assign in_service = (stk_cnt != '0);

    prio_intc_user_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .cfg        (src_cfg),
        .timed_mask (timed_mask_on),
        .hold_user  (nonest_q && in_service),
        .hit        (user_hit),
        .idx        (user_idx),
        .prio       (user_prio)
    );

    prio_intc_lvl_stack #(.DEPTH(STACK_DEPTH), .W(LVL_W)) u_stack (
        .clk  (clk),
        .rst  (rst),
        .push (take),
        .pop  (do_pop),
        .din  (cur_q),
        .dout (saved_level),
        .cnt  (stk_cnt),
        .ovf  (stack_err)
    );

    // trap flags and control register
    assign trap_clr = (reg_we && reg_kind == RK_TRAP) ? reg_wdata[NUM_TRAP-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q   <= '0;
            nonest_q <= 1'b0;
        end else begin
            trap_q <= (trap_q & ~trap_clr) | trap_event;
            if (reg_we && reg_kind == RK_CTRL) nonest_q <= reg_wdata[0];
        end
    end

    always_comb begin
        trap_any = 1'b0;
        trap_idx = '0;
        for (int i = 0; i < NUM_TRAP; i++) begin
            if (trap_q[i]) begin
                trap_any = 1'b1;
                trap_idx = TRAP_IDX_W'(i);
            end
        end
    end

    // final selection: traps outrank every peripheral source
    always_comb begin
        if (trap_any) begin
            win_any     = 1'b1;
            win_level   = trap_level(trap_idx);
            irq_index   = IDX_W'(trap_idx);
            irq_is_trap = 1'b1;
        end else begin
            win_any     = user_hit;
            win_level   = {1'b0, user_prio};
            irq_index   = user_idx;
            irq_is_trap = 1'b0;
        end
    end

    assign irq_valid = win_any && (win_level > cur_q);
    assign irq_level = win_level;
    assign take      = irq_ack && irq_valid;
    assign do_pop    = irq_ret && !take;

    always_ff @(posedge clk) begin
        if (rst)                          cur_q <= '0;
        else if (take)                    cur_q <= win_level;
        else if (do_pop && in_service)    cur_q <= saved_level;
        else if (ipl_we && !cur_q[LVL_W-1]) cur_q <= {1'b0, ipl_wdata};
    end

    assign cur_level = cur_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_kind)
            RK_CFG: begin
                if (32'(reg_idx) < NUM_SRC) reg_rdata = DATA_W'(src_cfg[reg_idx]);
            end
            RK_CTRL:  reg_rdata = DATA_W'(nonest_q);
            RK_TIMER: reg_rdata = DATA_W'(mask_count);
            RK_TRAP:  reg_rdata = DATA_W'(trap_q);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker (
    input logic       clk,
    input logic       rst,
    input logic       irq_valid,
    input logic       irq_is_trap,
    input logic [3:0] irq_level,
    input logic [3:0] cur_level,
    input logic       irq_ack,
    input logic       timed_mask_on,
    input logic       nonest,
    input logic       in_service,
    input logic       trap_any,
    input logic       stack_err
);

    assert_above_current_R2: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> irq_level > cur_level);

    assert_user_range_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_is_trap) |-> (irq_level != 4'd0 && !irq_level[3]));

    assert_trap_first_R4: assert property (@(posedge clk) disable iff (rst)
        (trap_any && !cur_level[3]) |-> (irq_valid && irq_is_trap));

    assert_timed_only_top_R6: assert property (@(posedge clk) disable iff (rst)
        (timed_mask_on && irq_valid && !irq_is_trap) |-> irq_level == 4'd7);

    assert_no_preempt_R7: assert property (@(posedge clk) disable iff (rst)
        (nonest && in_service && irq_valid) |-> irq_is_trap);

    assert_ack_level_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_valid) |=> cur_level == $past(irq_level));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> stack_err);

endmodule

bind prio_intc prio_intc_checker chk (
    .clk           (clk),
    .rst           (rst),
    .irq_valid     (irq_valid),
    .irq_is_trap   (irq_is_trap),
    .irq_level     (irq_level),
    .cur_level     (cur_level),
    .irq_ack       (irq_ack),
    .timed_mask_on (timed_mask_on),
    .nonest        (nonest_q),
    .in_service    (in_service),
    .trap_any      (trap_any),
    .stack_err     (stack_err)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;

    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] src_event = '0;
    logic [7:0]  trap_event = '0;
    logic        ipl_we = 1'b0;
    logic [2:0]  ipl_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_valid, irq_is_trap, timed_mask_on, stack_err;
    logic [4:0]  irq_index;
    logic [3:0]  irq_level, cur_level;

    always #2.5 clk = ~clk;

    prio_intc uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_event(src_event),
        .trap_event(trap_event), .ipl_we(ipl_we), .ipl_wdata(ipl_wdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid),
        .irq_is_trap(irq_is_trap), .irq_index(irq_index), .irq_level(irq_level),
        .cur_level(cur_level), .timed_mask_on(timed_mask_on), .stack_err(stack_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [4:0] sh_cfg [NS];
    int sh_ipl = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_irq(string req, bit v, bit t, int ix, int lv);
        check(req, "irq_valid", int'(irq_valid), int'(v));
        if (v) begin
            check(req, "irq_is_trap", int'(irq_is_trap), int'(t));
            check(req, "irq_index", int'(irq_index), ix);
            check(req, "irq_level", int'(irq_level), lv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] k, int i, int d);
        reg_we = 1'b1; reg_addr = {k, 5'(i)}; reg_wdata = 16'(d);
        step();
        reg_we = 1'b0;
        if (k == 2'd0) sh_cfg[i] = 5'(d);
    endtask

    task automatic rd(logic [1:0] k, int i, output int v);
        reg_addr = {k, 5'(i)};
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic set_ipl(int v);
        ipl_we = 1'b1; ipl_wdata = 3'(v);
        step();
        ipl_we = 1'b0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic ret_once();
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
    endtask

    task automatic trap_pulse(logic [7:0] m);
        trap_event = m; step(); trap_event = '0;
    endtask

    task automatic model(output bit v, output int ix, output int lv);
        lv = 0; ix = 0;
        for (int j = 0; j < NS; j++) begin
            if (sh_cfg[j][0] && sh_cfg[j][1] && int'(sh_cfg[j][4:2]) > lv) begin
                lv = int'(sh_cfg[j][4:2]);
                ix = j;
            end
        end
        v = (lv > sh_ipl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        for (int j = 0; j < NS; j++) sh_cfg[j] = 5'h10;
        void'($urandom(32'd4711));
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        rd(2'd0, 5, v);  check("R1", "cfg5 read", v, 16);
        rd(2'd3, 0, v);  check("R1", "trap flags", v, 0);
        check("R1", "cur_level", int'(cur_level), 0);
        check("R1", "irq_valid", int'(irq_valid), 0);
        check("R1", "timed_mask_on", int'(timed_mask_on), 0);
        check("R1", "stack_err", int'(stack_err), 0);

        // R2 request condition
        wr(2'd0, 3, 8'h13);  chk_irq("R2", 1, 0, 3, 4);
        wr(2'd0, 3, 8'h11);  chk_irq("R2", 0, 0, 0, 0);
        wr(2'd0, 3, 8'h03);  chk_irq("R2", 0, 0, 0, 0);
        wr(2'd0, 3, 8'h00);

        // R3 selection and tie break
        wr(2'd0, 10, 8'h1B); chk_irq("R3", 1, 0, 10, 6);
        wr(2'd0, 4, 8'h1B);  chk_irq("R3", 1, 0, 4, 6);
        wr(2'd0, 20, 8'h1F); chk_irq("R3", 1, 0, 20, 7);
        wr(2'd0, 4, 0); wr(2'd0, 10, 0); wr(2'd0, 20, 0);

        // R5 direct level writes
        wr(2'd0, 6, 8'h1F);
        set_ipl(6); chk_irq("R5", 1, 0, 6, 7);
        set_ipl(7); chk_irq("R5", 0, 0, 0, 0);
        check("R5", "cur_level", int'(cur_level), 7);
        set_ipl(0); chk_irq("R5", 1, 0, 6, 7);
        wr(2'd0, 6, 0);

        // R6 timed mask, exact length and reload
        wr(2'd0, 2, 8'h17);  chk_irq("R6", 1, 0, 2, 5);
        wr(2'd2, 0, 3);
        check("R6", "mask on", int'(timed_mask_on), 1);
        chk_irq("R6", 0, 0, 0, 0);
        step(); chk_irq("R6", 0, 0, 0, 0);
        step(); chk_irq("R6", 0, 0, 0, 0);
        step(); chk_irq("R6", 1, 0, 2, 5);
        wr(2'd2, 0, 3); step();
        wr(2'd2, 0, 3);       // reload while running
        step(); step(); chk_irq("R6", 0, 0, 0, 0);
        step(); chk_irq("R6", 1, 0, 2, 5);
        wr(2'd2, 0, 100);
        wr(2'd0, 9, 8'h1F);  chk_irq("R6", 1, 0, 9, 7);
        wr(2'd0, 9, 0);      chk_irq("R6", 0, 0, 0, 0);
        wr(2'd2, 0, 0);
        check("R6", "mask cancelled", int'(timed_mask_on), 0);
        chk_irq("R6", 1, 0, 2, 5);
        wr(2'd0, 2, 0);

        // R4 traps
        wr(2'd0, 9, 8'h1F);
        set_ipl(7); chk_irq("R4", 0, 0, 0, 0);
        wr(2'd2, 0, 50); wr(2'd1, 0, 1);
        trap_pulse(8'h04); chk_irq("R4", 1, 1, 2, 10);
        trap_pulse(8'h20); chk_irq("R4", 1, 1, 5, 13);
        wr(2'd3, 0, 8'h20); chk_irq("R9", 1, 1, 2, 10);
        rd(2'd3, 0, v); check("R9", "trap flags", v, 4);
        wr(2'd3, 0, 8'h04); chk_irq("R4", 0, 0, 0, 0);
        set_ipl(0); chk_irq("R4", 1, 0, 9, 7);
        wr(2'd2, 0, 0); wr(2'd1, 0, 0); wr(2'd0, 9, 0);

        // R8 / R7 service entry, nesting and return
        ack_once(); check("R8", "ack ignored", int'(cur_level), 0);
        wr(2'd0, 5, 8'h17); chk_irq("R8", 1, 0, 5, 5);
        ack_once();
        check("R8", "cur after ack", int'(cur_level), 5);
        chk_irq("R8", 0, 0, 0, 0);
        wr(2'd0, 12, 8'h1B); chk_irq("R8", 1, 0, 12, 6);
        wr(2'd1, 0, 1);      chk_irq("R7", 0, 0, 0, 0);
        trap_pulse(8'h01);   chk_irq("R7", 1, 1, 0, 8);
        wr(2'd3, 0, 8'h01);  chk_irq("R7", 0, 0, 0, 0);
        wr(2'd1, 0, 0);      chk_irq("R7", 1, 0, 12, 6);
        ret_once();
        check("R8", "cur after ret", int'(cur_level), 0);
        wr(2'd0, 12, 0);     chk_irq("R8", 1, 0, 5, 5);
        wr(2'd0, 5, 8'h16);  chk_irq("R8", 0, 0, 0, 0);
        wr(2'd0, 5, 0);

        // R10 stack depth and overflow
        wr(2'd0, 0, 8'h07); ack_once();
        wr(2'd0, 1, 8'h0B); ack_once();
        wr(2'd0, 2, 8'h0F); ack_once();
        wr(2'd0, 3, 8'h13); ack_once();
        check("R10", "cur at depth 4", int'(cur_level), 4);
        check("R10", "no error when full", int'(stack_err), 0);
        wr(2'd0, 4, 8'h17); ack_once();
        check("R10", "cur after overflow", int'(cur_level), 5);
        check("R10", "stack_err", int'(stack_err), 1);
        ret_once(); check("R10", "pop after overflow", int'(cur_level), 3);
        ret_once(); ret_once(); ret_once();
        check("R10", "stack drained", int'(cur_level), 0);
        ret_once(); check("R10", "pop when empty", int'(cur_level), 0);
        check("R10", "error sticky", int'(stack_err), 1);
        for (int j = 0; j < 5; j++) wr(2'd0, j, 0);

        // R9 event and clearing write in the same cycle
        wr(2'd0, 11, 8'h12);
        reg_we = 1'b1; reg_addr = {2'd0, 5'd11}; reg_wdata = 16'h12;
        src_event = 32'h1 << 11;
        step();
        reg_we = 1'b0; src_event = '0; sh_cfg[11] = 5'h13;
        rd(2'd0, 11, v); check("R9", "flag kept", v, 8'h13);
        chk_irq("R9", 1, 0, 11, 4);
        src_event = 32'h1 << 13; step(); src_event = '0; sh_cfg[13] = 5'h11;
        rd(2'd0, 13, v); check("R9", "event sets flag", v, 8'h11);
        chk_irq("R9", 1, 0, 11, 4);
        wr(2'd0, 11, 0); wr(2'd0, 13, 0);

        // R11 register readback
        wr(2'd1, 0, 1); rd(2'd1, 0, v); check("R11", "ctrl", v, 1);
        wr(2'd1, 0, 0);
        wr(2'd2, 0, 500); rd(2'd2, 0, v); check("R11", "timer", v, 500);
        step(); rd(2'd2, 0, v); check("R11", "timer counts", v, 499);
        wr(2'd2, 0, 0);

        // R3 random configurations against the bench model
        sh_ipl = 0;
        for (int n = 0; n < 300; n++) begin
            int i = int'($urandom % NS);
            int d = int'($urandom % 32);
            bit ev;
            int ei, el;
            wr(2'd0, i, d);
            if ($urandom % 4 == 0) begin
                sh_ipl = int'($urandom % 8);
                set_ipl(sh_ipl);
            end
            model(ev, ei, el);
            chk_irq("R3", ev, 0, ei, el);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule